// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Override

This block turns the event pulses of a PWM time base into output levels on two PWM pins (channel 0 is output A, channel 1 is output B). Six counter events are the inputs: the counter reaching zero, the counter reaching the period, and compare A and compare B matching while the counter counts up or down. Each channel has its own action register. The register holds a 2-bit code for every event. The code tells the channel to leave its pin alone, drive it low, drive it high or invert it. When more than one event arrives in the same clock, a fixed priority chooses the one action that is applied.

A continuous override register sits on top of the event logic. It holds a 2-bit field per channel and can pin either output to a fixed low or high level for as long as the field is set. Software uses the override to park a disabled channel at its inactive level. That level is low for normal polarity (set at zero, clear on compare up) and high for inverted polarity (clear at zero, set on compare up). Configuration arrives on a simple single-cycle write port. The event pulses and the write port are plain control inputs, so there is no flow control and no back-pressure.

Top module: `pwm_aq_top`

## Requirements
- R1: After reset both outputs are low, no override is active and every action code is 0.
- R2: Action codes are 2 bits: 0 leaves the output unchanged, 1 drives it low, 2 drives it high, 3 inverts it. A code takes effect on the clock edge at which its event is sampled.
- R3: The event input bit i selects the action field at bits 2i+1:2i of the channel's action register. The bits are: 0 counter zero, 1 counter period, 2 compare A up, 3 compare A down, 4 compare B up, 5 compare B down.
- R4: Write address c (0 or 1) loads the action register of channel c from wr_data[11:0]. Address 2 loads the override register from wr_data[3:0]. Other addresses are ignored. A write takes effect for events sampled from the next clock edge on.
- R5: When several events have a non-zero code in the same cycle, exactly one is applied. The order from highest to lowest is compare A up, compare A down, compare B up, compare B down, period, zero. An event whose code is 0 never masks a lower one.
- R6: The override field of channel c sits at bits 2c+1:2c: 0 means no override, 1 forces low, 2 forces high, 3 is treated as no override. A forced output shows the forced level from the cycle after the write, and events have no visible effect while the force lasts.
- R7: When the override is removed, the output keeps the forced level until the next event with a non-zero code.
- R8: With action codes of set-at-zero and clear-on-compare-A-up, output A is high from a zero event until a compare A up event (normal polarity). Swapping the two codes gives the inverted waveform.
- R9: The two channels are independent: an action or override for one channel never changes the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 6 | Event pulses, bit order as in R3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0/1 action A/B, 2 override |
| wr_data | input | 16 | Write data |
| pwm_o | output | 2 | Output levels, bit 0 = A, bit 1 = B |

## Verification
Each channel keeps one stored level, so a wrong level caused by a bad priority choice, a misdecoded field or a dropped release stays on the pin. It remains visible until the next event with a non-zero code corrects it, so a check one cycle after each event exposes it. An override that fails to block events shows up at the pin in the cycle after the offending pulse. An override that loses the stored level shows up in the first cycle after release. The bench sweeps every event against every code from both starting levels, and every pair of events with conflicting codes.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int NUM_EV = 6;
  localparam int ACT_W  = 2 * NUM_EV;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } act_code_e;

  // event bit positions
  localparam int EV_ZERO  = 0;
  localparam int EV_PRD   = 1;
  localparam int EV_CAU   = 2;
  localparam int EV_CAD   = 3;
  localparam int EV_CBU   = 4;
  localparam int EV_CBD   = 5;

  // rank 0 = lowest priority
  function automatic int ev_by_rank(input int rank);
    case (rank)
      0: ev_by_rank = EV_ZERO;
      1: ev_by_rank = EV_PRD;
      2: ev_by_rank = EV_CBD;
      3: ev_by_rank = EV_CBU;
      4: ev_by_rank = EV_CAD;
      default: ev_by_rank = EV_CAU;
    endcase
  endfunction
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16,
  parameter int AW  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic [NCH*ACT_W-1:0] act_flat,
  output logic [2*NCH-1:0]     frc_q
);
  localparam int FRC_ADDR = NCH;

  for (genvar c = 0; c < NCH; c++) begin : g_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        act_flat[c*ACT_W +: ACT_W] <= '0;
      else if (wr_en && (int'(wr_addr) == c))
        act_flat[c*ACT_W +: ACT_W] <= wr_data[ACT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frc_q <= '0;
    else if (wr_en && (int'(wr_addr) == FRC_ADDR))
      frc_q <= wr_data[2*NCH-1:0];
  end
endmodule

// File: rtl/pwm_aq_resolve.sv
module pwm_aq_resolve
  import pwm_aq_pkg::*;
(
  input  logic [NUM_EV-1:0] ev,
  input  logic [ACT_W-1:0]  act,
  output act_code_e         code
);
  always_comb begin
    code = ACT_NONE;
    for (int r = 0; r < NUM_EV; r++) begin
      if (ev[ev_by_rank(r)] && (act[2*ev_by_rank(r) +: 2] != 2'd0))
        code = act_code_e'(act[2*ev_by_rank(r) +: 2]);
    end
  end
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  act_code_e code,
  input  logic [1:0] frc,
  output logic      pwm
);
  logic lvl_q;
  logic forced;
  logic frc_lvl;

  assign forced  = (frc == 2'd1) || (frc == 2'd2);
  assign frc_lvl = (frc == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lvl_q <= 1'b0;
    else if (forced)
      lvl_q <= frc_lvl;
    else begin
      case (code)
        ACT_LOW:  lvl_q <= 1'b0;
        ACT_HIGH: lvl_q <= 1'b1;
        ACT_FLIP: lvl_q <= ~lvl_q;
        default:  lvl_q <= lvl_q;
      endcase
    end
  end

  assign pwm = forced ? frc_lvl : lvl_q;
endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 16,
  parameter int AW  = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH-1:0]    pwm_o
);
  logic [NCH*ACT_W-1:0] act_flat;
  logic [2*NCH-1:0]     frc_q;

  pwm_aq_regs #(.NCH(NCH), .DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .act_flat(act_flat), .frc_q(frc_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    act_code_e code;
    pwm_aq_resolve res_i (
      .ev(ev_i), .act(act_flat[c*ACT_W +: ACT_W]), .code(code)
    );
    pwm_aq_chan chan_i (
      .clk(clk), .rst_n(rst_n), .code(code),
      .frc(frc_q[2*c +: 2]), .pwm(pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk
  import pwm_aq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_EV-1:0]    ev_i,
  input logic                 wr_en,
  input logic [AW-1:0]        wr_addr,
  input logic [NCH*ACT_W-1:0] act_flat,
  input logic [2*NCH-1:0]     frc_q,
  input logic [NCH-1:0]       pwm_o
);
  logic frc_wr;
  assign frc_wr = wr_en && (int'(wr_addr) == NCH);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic free;
    assign free = (frc_q[2*c +: 2] != 2'd1) && (frc_q[2*c +: 2] != 2'd2);

    // R6
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_q[2*c +: 2] == 2'd1) |-> !pwm_o[c]);
    // R6
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_q[2*c +: 2] == 2'd2) |-> pwm_o[c]);
    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == '0 && free && !frc_wr) |=> $stable(pwm_o[c]));
    // R5
    cau_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[EV_CAU] && act_flat[c*ACT_W + 2*EV_CAU +: 2] == 2'd2 && free && !frc_wr)
      |=> pwm_o[c]);
    // R5
    cau_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[EV_CAU] && act_flat[c*ACT_W + 2*EV_CAU +: 2] == 2'd1 && free && !frc_wr)
      |=> !pwm_o[c]);
    // R2
    only_zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == 6'b000001 && act_flat[c*ACT_W +: 2] == 2'd3 && free && !frc_wr)
      |=> pwm_o[c] != $past(pwm_o[c]));
  end
endmodule

bind pwm_aq_top pwm_aq_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .wr_addr(wr_addr),
  .act_flat(act_flat), .frc_q(frc_q), .pwm_o(pwm_o)
);

// File: tb/pwm_aq_top_tb_top.sv
`timescale 1ns/1ps
module pwm_aq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ev_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  pwm_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pwm_aq_top dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    ev_i = e;
    @(negedge clk);
    ev_i = '0;
  endtask

  // park channel c at level l through override then release
  task automatic set_level(input int c, input logic l);
    wr(2, (l ? 2 : 1) << (2 * c));
    wr(2, 0);
  endtask

  function automatic logic apply(input int code, input logic l);
    case (code)
      1: apply = 1'b0;
      2: apply = 1'b1;
      3: apply = ~l;
      default: apply = l;
    endcase
  endfunction

  function automatic int rank(input int e);
    case (e)
      2: rank = 5;
      3: rank = 4;
      4: rank = 3;
      5: rank = 2;
      1: rank = 1;
      default: rank = 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state; events with all-zero codes do nothing
    chk("R1 a", pwm_o[0], 1'b0);
    chk("R1 b", pwm_o[1], 1'b0);
    pulse(6'h3f);
    chk("R1 none a", pwm_o[0], 1'b0);
    chk("R1 none b", pwm_o[1], 1'b0);

    // R2 R3 sweep: every channel, event, code, start level
    for (int c = 0; c < 2; c++)
      for (int e = 0; e < 6; e++)
        for (int code = 0; code < 4; code++)
          for (int l = 0; l < 2; l++) begin
            logic other;
            set_level(c, 1'(l));
            other = pwm_o[1-c];
            wr(c, code << (2 * e));
            pulse(6'(1 << e));
            chk($sformatf("R3 ch%0d ev%0d code%0d", c, e, code),
                pwm_o[c], apply(code, 1'(l)));
            // R9 other channel untouched
            chk("R9 other", pwm_o[1-c], other);
            wr(c, 0);
          end

    // R5 pair sweep on channel 0
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        if (i != j) begin
          int hi;
          hi = (rank(i) > rank(j)) ? i : j;
          set_level(0, 1'b0);
          wr(0, (2 << (2 * i)) | (1 << (2 * j)));
          pulse(6'((1 << i) | (1 << j)));
          chk($sformatf("R5 ev%0d/%0d", i, j), pwm_o[0], (hi == i));
          // a none code on the higher event does not mask
          set_level(0, 1'b0);
          wr(0, 2 << (2 * ((hi == i) ? j : i)));
          pulse(6'((1 << i) | (1 << j)));
          chk($sformatf("R5 mask ev%0d/%0d", i, j), pwm_o[0], 1'b1);
        end
      end

    // R4 write timing: write and event in the same cycle use old code
    set_level(0, 1'b0);
    wr(0, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0002; ev_i = 6'h01;
    @(negedge clk);
    wr_en = 1'b0; ev_i = '0;
    chk("R4 old code", pwm_o[0], 1'b0);
    pulse(6'h01);
    chk("R4 new code", pwm_o[0], 1'b1);
    // R4 address 3 ignored
    wr(3, 16'hffff);
    chk("R4 addr3 a", pwm_o[0], 1'b1);
    chk("R4 addr3 b", pwm_o[1], 1'b0);
    // R4 upper data bits do not reach the action register
    wr(0, 16'hf000);
    pulse(6'h3f);
    chk("R4 upper", pwm_o[0], 1'b1);

    // R6 force blocks events, R7 resume from forced level
    wr(0, 16'h0003);
    wr(2, 4'b0001);
    chk("R6 force low", pwm_o[0], 1'b0);
    pulse(6'h01);
    chk("R6 ev blocked", pwm_o[0], 1'b0);
    wr(2, 4'b0010);
    chk("R6 force high", pwm_o[0], 1'b1);
    pulse(6'h01);
    chk("R6 ev blocked hi", pwm_o[0], 1'b1);
    wr(2, 4'b0011);
    chk("R6 code3 no force", pwm_o[0], 1'b1);
    wr(2, 4'b0010);
    wr(2, 0);
    chk("R7 resume", pwm_o[0], 1'b1);
    pulse(6'h01);
    chk("R7 next event", pwm_o[0], 1'b0);
    // R6 channel B force high
    wr(2, 4'b1000);
    chk("R6 b high", pwm_o[1], 1'b1);
    chk("R9 a kept", pwm_o[0], 1'b0);
    wr(2, 0);

    // R8 normal and inverted polarity waveforms on channel A
    wr(0, (2 << 0) | (1 << 4));
    pulse(6'h01);
    chk("R8 normal zero", pwm_o[0], 1'b1);
    pulse(6'h04);
    chk("R8 normal cmp", pwm_o[0], 1'b0);
    wr(0, (1 << 0) | (2 << 4));
    pulse(6'h01);
    chk("R8 inv zero", pwm_o[0], 1'b0);
    pulse(6'h04);
    chk("R8 inv cmp", pwm_o[0], 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule